// File: doc/BRIEF.md
# LIN Bus Wake-up Filter

This block decides when activity on a LIN bus is a genuine remote wake-up request while the transceiver sits in one of its low-power states. The mode controller raises `arm` while silent or sleep mode is active. Two comparator flags arrive from the analog front end. `bus_dom` reports that the bus is below the normal dominant threshold. `bus_weak_low` reports a shallow drop, where the bus sits under the supply minus 3.3 V but still above 0.6 of the supply. Both flags are asynchronous to the block clock and are synchronized inside the block.

Level sampling alone is not enough to report a wake-up. The block first needs a recessive-to-dominant transition on one of the flags. That flag must then stay asserted for a filter time, measured in `tick` periods, where `tick` is a one-cycle strobe from a shared timebase. For the normal-threshold path the filter time corresponds to the tbus window, nominally 90 µs and between 30 and 150 µs. The shallow-drop path has a separate filter time of its own. When a qualifying event occurs, the block emits a single-cycle `wake_pulse`, which the mode controller uses to move to pre-normal mode. After that pulse the block stays quiet until it is disarmed and armed again. All pins are plain control and status signals, and there is no streamed data, so no valid/ready handshake applies.

Top module: `lin_wake_filter`

## Requirements
- R1: While `arm` is low, `wake_pulse` stays low whatever the bus flags do. Dropping `arm` in the middle of a filter interval abandons that interval.
- R2: With `arm` high and `tick` high every cycle, a 0-to-1 change of `bus_dom` held long enough gives a pulse. With SYNC_STAGES=2, the pulse appears exactly DOM_TICKS+4 cycles after the clock edge that first samples the new level, counted from the cycle in which the input changed.
- R3: If `bus_dom` returns to 0 before the filter time completes, no pulse results and the partial count is discarded. A later fresh 0-to-1 change needs the full filter time again.
- R4: A flag already at 1 when `arm` rises does not start a filter interval. Only a subsequent 0-to-1 change does.
- R5: `bus_weak_low` has its own path with filter time WEAK_TICKS, and it follows the same edge-then-hold rule with the same latency. A shallow drop shorter than that time gives no pulse.
- R6: At most one pulse is issued per arming, even when both paths qualify or new edges follow. Disarming and re-arming enables one new pulse.
- R7: `wake_pulse` is never high for two consecutive cycles.
- R8: The filter time counts `tick` strobes, not clock cycles. While `tick` is low, a held level makes no progress. When ticks resume, the count completes after the remaining number of ticks, giving a pulse one cycle after the last tick needed.
- R9: After reset, `wake_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase strobe; each high cycle counts as one filter unit |
| arm | input | 1 | High while a low-power mode is active |
| bus_dom | input | 1 | Asynchronous flag, 1 when the bus is dominant |
| bus_weak_low | input | 1 | Asynchronous flag, 1 on a shallow bus drop |
| wake_pulse | output | 1 | One-cycle remote wake-up indication |

## Verification
A counter that fails to clear on release shows up as a pulse that arrives early on the next fresh edge, or as a pulse caused by a glitch that is too short. Each of these is seen within one filter time of the stimulus. An edge detector that accepts a level already present at arming gives a pulse about DOM_TICKS cycles after `arm` rises, while none is expected. A lost or stuck one-shot latch shows up as a second pulse within the same arming, or as no pulse after re-arming. Every expected pulse is scored against its exact cycle.

// File: rtl/lwf_pkg.sv
package lwf_pkg;
  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_COUNT = 2'd1,
    FS_SPENT = 2'd2
  } filt_state_e;

  localparam int unsigned N_PATHS      = 2;
  localparam int unsigned PATH_DEEP    = 0;
  localparam int unsigned PATH_SHALLOW = 1;
endpackage

// File: rtl/lwf_sync.sv
module lwf_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lwf_edge_filter.sv
module lwf_edge_filter
  import lwf_pkg::*;
#(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic lvl,
  output logic hit
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  filt_state_e st;
  logic [CW-1:0] cnt;
  logic prev_lvl;
  logic onset;

  assign onset = lvl & ~prev_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= FS_IDLE;
      cnt      <= '0;
      hit      <= 1'b0;
      prev_lvl <= 1'b0;
    end else begin
      prev_lvl <= lvl;
      hit      <= 1'b0;
      if (clr) begin
        st  <= FS_IDLE;
        cnt <= '0;
      end else begin
        unique case (st)
          FS_IDLE: begin
            if (onset) begin
              st  <= FS_COUNT;
              cnt <= '0;
            end
          end
          FS_COUNT: begin
            if (!lvl) begin
              st  <= FS_IDLE;
              cnt <= '0;
            end else if (tick) begin
              if (cnt == LAST) begin
                hit <= 1'b1;
                st  <= FS_SPENT;
                cnt <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          FS_SPENT: st <= FS_SPENT;
          default: begin
            st  <= FS_IDLE;
            cnt <= '0;
          end
        endcase
      end
    end
  end

  p_hit_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);

  p_release_aborts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FS_COUNT && !lvl && !clr) |=> (st == FS_IDLE && cnt == '0));

  p_tick_gates_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FS_COUNT && lvl && !tick && !clr) |=> (st == FS_COUNT && $stable(cnt)));

  p_needs_onset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FS_IDLE && !onset) |=> (st == FS_IDLE));
endmodule

// File: rtl/lin_wake_filter.sv
module lin_wake_filter
  import lwf_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DOM_TICKS   = 8,
  parameter int unsigned WEAK_TICKS  = 12,
  parameter bit          WEAK_EN     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic arm,
  input  logic bus_dom,
  input  logic bus_weak_low,
  output logic wake_pulse
);
  logic [N_PATHS-1:0] raw_flags;
  logic [N_PATHS-1:0] s_flags;
  logic [N_PATHS-1:0] path_hit;
  logic               fired;

  assign raw_flags[PATH_DEEP]    = bus_dom;
  assign raw_flags[PATH_SHALLOW] = bus_weak_low;

  lwf_sync #(.W(N_PATHS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_flags),
    .q     (s_flags)
  );

  lwf_edge_filter #(.LIMIT(DOM_TICKS)) u_deep (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (~arm),
    .tick  (tick),
    .lvl   (s_flags[PATH_DEEP]),
    .hit   (path_hit[PATH_DEEP])
  );

  generate
    if (WEAK_EN) begin : g_shallow
      lwf_edge_filter #(.LIMIT(WEAK_TICKS)) u_shallow (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (~arm),
        .tick  (tick),
        .lvl   (s_flags[PATH_SHALLOW]),
        .hit   (path_hit[PATH_SHALLOW])
      );
    end else begin : g_no_shallow
      assign path_hit[PATH_SHALLOW] = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired      <= 1'b0;
      wake_pulse <= 1'b0;
    end else if (!arm) begin
      fired      <= 1'b0;
      wake_pulse <= 1'b0;
    end else begin
      wake_pulse <= (|path_hit) & ~fired;
      if (|path_hit) fired <= 1'b1;
    end
  end

  p_quiet_disarmed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> !wake_pulse);

  p_once_per_arming_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fired && arm) |=> !wake_pulse);

  p_pulse_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  p_pulse_from_filter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(|path_hit));
endmodule

// File: tb/sim_lin_wake_filter.sv
module sim_lin_wake_filter;
  localparam int DOM  = 8;
  localparam int WEAK = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic arm = 1'b0;
  logic bus_dom = 1'b0;
  logic bus_weak_low = 1'b0;
  logic wake_pulse;

  lin_wake_filter #(.SYNC_STAGES(2), .DOM_TICKS(DOM), .WEAK_TICKS(WEAK), .WEAK_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm(arm),
    .bus_dom(bus_dom), .bus_weak_low(bus_weak_low), .wake_pulse(wake_pulse)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int at; string req; } exp_t;
  exp_t exp_q[$];
  int n_vec = 0;
  int n_bad = 0;
  int stray = 0;

  // Monitor: pops the scoreboard when a pulse arrives in its expected cycle.
  always @(negedge clk) begin
    if (rst_n && wake_pulse) begin
      if (exp_q.size() > 0 && exp_q[0].at == cyc) begin
        n_vec++;
        void'(exp_q.pop_front());
      end else begin
        stray++;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_wake(input int delta, input string req);
    exp_t e;
    e.at  = cyc + delta;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic settle(input int n, input string req);
    step(n);
    n_vec++;
    if (stray != 0 || exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL %s: unexpected pulses=%0d missing pulses=%0d, expected 0 and 0",
               req, stray, exp_q.size());
    end
    exp_q.delete();
    stray = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    n_vec++;
    if (wake_pulse !== 1'b0) begin
      n_bad++;
      $display("FAIL R9: wake_pulse=%0b expected 0", wake_pulse);
    end

    // R1: disarmed, long dominant, then disarm mid-count
    bus_dom = 1'b1; step(40); bus_dom = 1'b0;
    settle(10, "R1");
    arm = 1'b1; step(4); bus_dom = 1'b1; step(5); arm = 1'b0; step(30); bus_dom = 1'b0;
    settle(10, "R1");

    // R2 and R7: basic wake with exact latency, single-cycle width
    arm = 1'b1; step(5);
    bus_dom = 1'b1; expect_wake(DOM + 4, "R2");
    step(30); bus_dom = 1'b0;
    settle(5, "R2 R7");
    arm = 1'b0; step(3);

    // R3: short glitch then fresh edge needs full time
    arm = 1'b1; step(5);
    bus_dom = 1'b1; step(DOM - 1); bus_dom = 1'b0; step(4);
    bus_dom = 1'b1; expect_wake(DOM + 4, "R3");
    step(30); bus_dom = 1'b0;
    settle(5, "R3");
    arm = 1'b0; step(3);

    // R4: level present at arming is ignored
    bus_dom = 1'b1; step(5); arm = 1'b1; step(40);
    settle(1, "R4");
    bus_dom = 1'b0; step(5);
    bus_dom = 1'b1; expect_wake(DOM + 4, "R4");
    step(30); bus_dom = 1'b0;
    settle(5, "R4");
    arm = 1'b0; step(3);

    // R5: shallow-drop path, short then long
    arm = 1'b1; step(5);
    bus_weak_low = 1'b1; step(WEAK - 1); bus_weak_low = 1'b0;
    settle(10, "R5");
    bus_weak_low = 1'b1; expect_wake(WEAK + 4, "R5");
    step(30); bus_weak_low = 1'b0;
    settle(5, "R5");
    arm = 1'b0; step(3);

    // R6: one pulse per arming, re-arm enables a new one
    arm = 1'b1; step(5);
    bus_dom = 1'b1; expect_wake(DOM + 4, "R6");
    step(30); bus_dom = 1'b0; step(5);
    bus_dom = 1'b1; step(30); bus_dom = 1'b0;
    bus_weak_low = 1'b1; step(30); bus_weak_low = 1'b0;
    settle(5, "R6");
    arm = 1'b0; step(3); arm = 1'b1; step(3);
    bus_dom = 1'b1; expect_wake(DOM + 4, "R6");
    step(30); bus_dom = 1'b0;
    settle(5, "R6");
    arm = 1'b0; step(3);

    // R6: both paths qualify together, one pulse at the deep-path time
    arm = 1'b1; step(5);
    bus_dom = 1'b1; bus_weak_low = 1'b1; expect_wake(DOM + 4, "R6");
    step(40); bus_dom = 1'b0; bus_weak_low = 1'b0;
    settle(5, "R6");
    arm = 1'b0; step(3);

    // R8: no progress without ticks, completes after resuming
    arm = 1'b1; step(5);
    tick = 1'b0; bus_dom = 1'b1; step(40);
    settle(1, "R8");
    tick = 1'b1; expect_wake(DOM + 1, "R8");
    step(20); bus_dom = 1'b0;
    settle(5, "R8");
    arm = 1'b0; step(3);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule